// File: doc/BRIEF.md
# Interrupt Flush Controller for a Multithreaded In-Order Pipeline

This block sits next to a multithreaded in-order pipeline and checks every hardware thread for a pending interrupt on every clock cycle. It makes this check whether or not the pipeline is idle. A thread is serviced when its pending flag is set and it carries a non-null cause code. In that same cycle the block acknowledges the interrupt source, flushes the thread, and tells the shared execution resources to drop all work for that thread. One cycle later it presents a trap request for the thread. The cycle between the flush and the trap request means the trap takes effect at the end of the servicing cycle, after the flush.

The flush is carried by a per-thread trap token. The token's sequence tag is zero, so every in-flight instruction of the thread is younger than it and is removed. The token is launched from two stages: the final stage and the stage just before the back end. In this project, a squash launched at stage s flushes stages 0 through s of that thread. Each thread has its own lane of outputs, so any number of threads can be serviced in one cycle. The block has no data stream, so every pin is a plain control or status signal with no back-pressure.

Top module: `intr_flush_ctl`

## Requirements
- R1: While rst_n is low, every output is 0. This holds even when interrupts are pending.
- R2: Thread t is serviced in a cycle only when intr_pending[t] is 1 and its 4-bit cause field intr_cause[t*4 +: 4] is non-zero. A cause of 0 is a null fault, and pending set to 0 means no interrupt. Either one leaves every output of lane t at 0.
- R3: intr_ack[t] is 1 in exactly the cycles in which thread t is serviced. It is combinational, with no delay.
- R4: When thread t is serviced, lane t of sq_issue (bits t*NUM_STAGES +: NUM_STAGES) has exactly two bits set: stage NUM_STAGES-1 and stage BACKEND_START-1. With the defaults this is 5'b10100.
- R5: When thread t is serviced, every bit of lane t of sq_kill is 1, because a squash from stage s flushes stages 0..s.
- R6: A serviced lane carries the trap token: its sq_seq field (16 bits) is 0 and its sq_tid field equals t.
- R7: res_squash_all[t] is 1 in the same cycle as intr_ack[t].
- R8: In the cycle after thread t is serviced, trap_valid[t] is 1, trap_cause lane t holds the cause that was serviced, and trap_tid lane t equals t. All three are 0 in every other cycle.
- R9: Threads serviced in the same cycle each get their own full set of outputs, and neither thread's outputs are affected by the other.
- R10: An interrupt held pending is serviced again on every cycle. Servicing is not a single pulse per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| intr_pending | input | NUM_THREADS | Per-thread pending-interrupt flag |
| intr_cause | input | NUM_THREADS*CAUSE_W | Per-thread cause code, 0 = null |
| intr_ack | output | NUM_THREADS | Acknowledge to the interrupt source |
| sq_issue | output | NUM_THREADS*NUM_STAGES | Stages issuing a squash, per thread lane |
| sq_kill | output | NUM_THREADS*NUM_STAGES | Stages flushed, per thread lane |
| sq_tid | output | NUM_THREADS*TID_W | Thread ID of the token, per lane |
| sq_seq | output | NUM_THREADS*SEQ_W | Sequence tag of the token, per lane |
| res_squash_all | output | NUM_THREADS | Squash-all broadcast to shared resources |
| trap_valid | output | NUM_THREADS | Trap request, one cycle after service |
| trap_tid | output | NUM_THREADS*TID_W | Trap thread ID, per lane |
| trap_cause | output | NUM_THREADS*CAUSE_W | Trap cause, per lane |

## Verification
The bench applies several input patterns, and each one separates a different failure:
- A single interrupt on thread 0 and then on thread 1 shows whether the lane mapping is correct.
- Both threads at once shows whether the lanes are independent.
- Pending with a zero cause, and a non-zero cause without pending, both check the qualification rule.
- A request held for several cycles rules out edge-triggered servicing.
- Pending interrupts during reset show whether reset masks the outputs.

Each trap expectation is queued when the stimulus is applied. It is compared one cycle later, which confirms the one-cycle deferral.

// File: rtl/intr_flush_pkg.sv
package intr_flush_pkg;
  localparam int unsigned MAX_STAGES = 32;

  // Bits 0..top set: the stages flushed by a squash launched at stage top.
  function automatic logic [MAX_STAGES-1:0] upto_mask(input int unsigned top);
    logic [MAX_STAGES-1:0] m;
    m = '0;
    for (int unsigned i = 0; i < MAX_STAGES; i++) begin
      if (i <= top) m[i] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/intr_qual.sv
module intr_qual #(
  parameter int unsigned NUM_THREADS = 2,
  parameter int unsigned CAUSE_W     = 4
) (
  input  logic                           rst_n,
  input  logic [NUM_THREADS-1:0]         pend_i,
  input  logic [NUM_THREADS*CAUSE_W-1:0] cause_i,
  output logic [NUM_THREADS-1:0]         svc_o
);
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_lane
    logic real_fault;
    assign real_fault = |cause_i[t*CAUSE_W +: CAUSE_W];
    assign svc_o[t]   = rst_n & pend_i[t] & real_fault;
  end
endmodule

// File: rtl/squash_gen.sv
module squash_gen
  import intr_flush_pkg::*;
#(
  parameter int unsigned NUM_STAGES    = 5,
  parameter int unsigned BACKEND_START = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  svc_i,
  output logic [NUM_STAGES-1:0] issue_o,
  output logic [NUM_STAGES-1:0] kill_o
);
  localparam int unsigned LAST_ST  = NUM_STAGES - 1;
  localparam int unsigned FRONT_ST = BACKEND_START - 1;

  for (genvar s = 0; s < NUM_STAGES; s++) begin : g_issue
    if (s == LAST_ST || s == FRONT_ST) begin : g_src
      assign issue_o[s] = svc_i;
    end else begin : g_none
      assign issue_o[s] = 1'b0;
    end
  end

  always_comb begin
    logic [MAX_STAGES-1:0] acc;
    acc = '0;
    for (int unsigned s = 0; s < NUM_STAGES; s++) begin
      if (issue_o[s]) acc = acc | upto_mask(s);
    end
    kill_o = acc[NUM_STAGES-1:0];
  end

  // R5: a squash from the final stage must flush the whole lane
  a_r5_full_kill: assert property (@(posedge clk) disable iff (!rst_n)
    issue_o[LAST_ST] |-> (&kill_o));

  if (FRONT_ST != LAST_ST) begin : g_two
    // R4: two launch points whenever the lane is serviced
    a_r4_two_points: assert property (@(posedge clk) disable iff (!rst_n)
      svc_i |-> ($countones(issue_o) == 2));
  end
endmodule

// File: rtl/trap_reg.sv
module trap_reg #(
  parameter int unsigned NUM_THREADS = 2,
  parameter int unsigned CAUSE_W     = 4,
  parameter int unsigned TID_W       = 1
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NUM_THREADS-1:0]         svc_i,
  input  logic [NUM_THREADS*CAUSE_W-1:0] cause_i,
  output logic [NUM_THREADS-1:0]         trap_valid_o,
  output logic [NUM_THREADS*TID_W-1:0]   trap_tid_o,
  output logic [NUM_THREADS*CAUSE_W-1:0] trap_cause_o
);
  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_lane
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        trap_valid_o[t]                    <= 1'b0;
        trap_tid_o[t*TID_W +: TID_W]       <= '0;
        trap_cause_o[t*CAUSE_W +: CAUSE_W] <= '0;
      end else begin
        trap_valid_o[t]                    <= svc_i[t];
        trap_tid_o[t*TID_W +: TID_W]       <= svc_i[t] ? TID_W'(t) : '0;
        trap_cause_o[t*CAUSE_W +: CAUSE_W] <= svc_i[t] ? cause_i[t*CAUSE_W +: CAUSE_W] : '0;
      end
    end
  end

  // R8: trap lands exactly one cycle after service
  a_r8_trap_follows: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (trap_valid_o == $past(svc_i)));
endmodule

// File: rtl/intr_flush_ctl.sv
module intr_flush_ctl #(
  parameter int unsigned NUM_THREADS   = 2,
  parameter int unsigned NUM_STAGES    = 5,
  parameter int unsigned BACKEND_START = 3,
  parameter int unsigned CAUSE_W       = 4,
  parameter int unsigned SEQ_W         = 16,
  localparam int unsigned TID_W        = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [NUM_THREADS-1:0]            intr_pending,
  input  logic [NUM_THREADS*CAUSE_W-1:0]    intr_cause,
  output logic [NUM_THREADS-1:0]            intr_ack,
  output logic [NUM_THREADS*NUM_STAGES-1:0] sq_issue,
  output logic [NUM_THREADS*NUM_STAGES-1:0] sq_kill,
  output logic [NUM_THREADS*TID_W-1:0]      sq_tid,
  output logic [NUM_THREADS*SEQ_W-1:0]      sq_seq,
  output logic [NUM_THREADS-1:0]            res_squash_all,
  output logic [NUM_THREADS-1:0]            trap_valid,
  output logic [NUM_THREADS*TID_W-1:0]      trap_tid,
  output logic [NUM_THREADS*CAUSE_W-1:0]    trap_cause
);
  localparam logic [SEQ_W-1:0] TOKEN_SEQ = '0;

  logic [NUM_THREADS-1:0] svc;

  intr_qual #(.NUM_THREADS(NUM_THREADS), .CAUSE_W(CAUSE_W)) u_qual (
    .rst_n  (rst_n),
    .pend_i (intr_pending),
    .cause_i(intr_cause),
    .svc_o  (svc)
  );

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
    squash_gen #(.NUM_STAGES(NUM_STAGES), .BACKEND_START(BACKEND_START)) u_sq (
      .clk    (clk),
      .rst_n  (rst_n),
      .svc_i  (svc[t]),
      .issue_o(sq_issue[t*NUM_STAGES +: NUM_STAGES]),
      .kill_o (sq_kill[t*NUM_STAGES +: NUM_STAGES])
    );
    assign sq_tid[t*TID_W +: TID_W] = svc[t] ? TID_W'(t) : '0;
    assign sq_seq[t*SEQ_W +: SEQ_W] = TOKEN_SEQ;

    // R6: a serviced lane carries its own thread's zero-tagged token
    a_r6_token: assert property (@(posedge clk) disable iff (!rst_n)
      intr_ack[t] |-> (sq_tid[t*TID_W +: TID_W] == TID_W'(t)
                       && sq_seq[t*SEQ_W +: SEQ_W] == '0));
  end

  assign intr_ack       = svc;
  assign res_squash_all = svc;

  trap_reg #(.NUM_THREADS(NUM_THREADS), .CAUSE_W(CAUSE_W), .TID_W(TID_W)) u_trap (
    .clk         (clk),
    .rst_n       (rst_n),
    .svc_i       (svc),
    .cause_i     (intr_cause),
    .trap_valid_o(trap_valid),
    .trap_tid_o  (trap_tid),
    .trap_cause_o(trap_cause)
  );

  for (genvar t = 0; t < NUM_THREADS; t++) begin : g_chk
    // R7: resource broadcast goes with the flush of the same lane
    a_r7_res_with_flush: assert property (@(posedge clk) disable iff (!rst_n)
      res_squash_all[t] |-> sq_kill[t*NUM_STAGES]);
    // R3: acknowledge only for a lane that is flushed
    a_r3_ack_flushes: assert property (@(posedge clk) disable iff (!rst_n)
      intr_ack[t] == sq_issue[t*NUM_STAGES + NUM_STAGES - 1]);
  end
endmodule

// File: tb/test_intr_flush_ctl.sv
`timescale 1ns/1ps
module test_intr_flush_ctl;
  localparam int NT = 2, NS = 5, CW = 4, SW = 16, TW = 1;

  logic clk = 0, rst_n = 0;
  logic [NT-1:0]    intr_pending = '0;
  logic [NT*CW-1:0] intr_cause = '0;
  logic [NT-1:0]    intr_ack, res_squash_all, trap_valid;
  logic [NT*NS-1:0] sq_issue, sq_kill;
  logic [NT*TW-1:0] sq_tid, trap_tid;
  logic [NT*SW-1:0] sq_seq;
  logic [NT*CW-1:0] trap_cause;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  intr_flush_ctl i_intr_flush_ctl (
    .clk(clk), .rst_n(rst_n), .intr_pending(intr_pending), .intr_cause(intr_cause),
    .intr_ack(intr_ack), .sq_issue(sq_issue), .sq_kill(sq_kill), .sq_tid(sq_tid),
    .sq_seq(sq_seq), .res_squash_all(res_squash_all), .trap_valid(trap_valid),
    .trap_tid(trap_tid), .trap_cause(trap_cause)
  );

  typedef struct packed {
    logic [NT-1:0]    v;
    logic [NT*CW-1:0] c;
  } trap_exp_t;
  trap_exp_t q[$];

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Driver: apply one cycle of stimulus, check same-cycle outputs, queue trap expectation
  task automatic step(input logic [NT-1:0] p, input logic [NT*CW-1:0] c, input string tag);
    trap_exp_t e;
    logic [NT-1:0] s;
    @(negedge clk);
    intr_pending = p;
    intr_cause   = c;
    #1;
    e.v = '0;
    e.c = '0;
    for (int t = 0; t < NT; t++) begin
      s[t] = p[t] && (c[t*CW +: CW] != 0);
      if (s[t]) begin
        e.v[t] = 1'b1;
        e.c[t*CW +: CW] = c[t*CW +: CW];
      end
    end
    for (int t = 0; t < NT; t++) begin
      check({tag, " R2/R3 ack"},   64'(intr_ack[t]), 64'(s[t]));
      check({tag, " R4 issue"},    64'(sq_issue[t*NS +: NS]), s[t] ? 64'b10100 : 64'd0);
      check({tag, " R5 kill"},     64'(sq_kill[t*NS +: NS]),  s[t] ? 64'b11111 : 64'd0);
      check({tag, " R6 tid"},      64'(sq_tid[t*TW +: TW]),   s[t] ? 64'(t) : 64'd0);
      check({tag, " R6 seq"},      64'(sq_seq[t*SW +: SW]),   64'd0);
      check({tag, " R7 res"},      64'(res_squash_all[t]),    64'(s[t]));
    end
    q.push_back(e);
  endtask

  // Monitor: after each edge, compare trap outputs with the queued expectation (R8)
  always @(posedge clk) begin
    trap_exp_t e;
    #1;
    if (q.size() > 0) begin
      e = q.pop_front();
      check("R8 trap_valid", 64'(trap_valid), 64'(e.v));
      check("R8 trap_cause", 64'(trap_cause), 64'(e.c));
      for (int t = 0; t < NT; t++)
        check("R8 trap_tid", 64'(trap_tid[t*TW +: TW]), e.v[t] ? 64'(t) : 64'd0);
    end
  end

  initial begin
    #40000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    intr_pending = 2'b11;
    intr_cause   = {4'h3, 4'h7};
    repeat (3) @(negedge clk);
    #1;
    check("R1 ack in reset",   64'(intr_ack), 64'd0);
    check("R1 issue in reset", 64'(sq_issue), 64'd0);
    check("R1 res in reset",   64'(res_squash_all), 64'd0);
    check("R1 trap in reset",  64'(trap_valid), 64'd0);
    @(negedge clk);
    intr_pending = '0;
    rst_n = 1;
    step(2'b00, 8'h00, "idle");
    step(2'b01, 8'h05, "t0 only");
    step(2'b10, 8'hA0, "t1 only R9");
    step(2'b11, 8'h9C, "both R9");
    step(2'b11, 8'h0C, "t1 null cause R2");
    step(2'b00, 8'hFF, "causes without pending R2");
    step(2'b01, 8'h30, "t0 pending null R2");
    step(2'b10, 8'h21, "held R10 a");
    step(2'b10, 8'h21, "held R10 b");
    step(2'b10, 8'h21, "held R10 c");
    step(2'b11, 8'hF1, "both again R9");
    step(2'b00, 8'h00, "flush");
    repeat (2) @(negedge clk);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule